// File: doc/BRIEF.md
# I2C Read Master with Stretch-Controlled Receive

This block is a register-driven I2C bus master dedicated to read transfers. Software asks for a START, writes the 7-bit target address plus a read bit into the data register, and then collects incoming bytes one by one through that same register while watching a small set of status flags. The receive path holds two bytes: a shift register collects bits from the bus and hands each finished byte to a data register. When software has not yet emptied the data register by the time the next byte finishes, the controller keeps SCL low until software reads.

This two-byte buffering gives software time to end a transfer cleanly. It waits for the stall while three bytes remain, clears the acknowledge enable, and then reads. The final byte is then received with a NACK, and a STOP (or a repeated START) that software programs in the meantime goes out as soon as that byte is done. Bus timing comes from a divider that splits every SCL period into four quarter steps.

The sequencer moves through these states. IDLE goes to START on a start request. START goes to WAIT_ADDR once the condition is on the bus. WAIT_ADDR goes to ADDR when the address is written. ADDR goes to ADDR_HOLD on an ACK and to STOP on a NACK. ADDR_HOLD goes to RX_BIT once the address flag is cleared. RX_BIT goes to RX_ACK after eight bits. RX_ACK goes to STRETCH if the data register is full, and otherwise leaves by the byte-end decision. STRETCH leaves by the same decision when the data register is read. The byte-end decision picks STOP, RESTART or RX_BIT. RESTART goes to START, and STOP goes to IDLE.

Top module: `i2c_rd_master`

## Requirements
- R1: Writing 1 to control bit 0 (register select 0) makes the controller drive SDA low while SCL is high (a START). It then sets status-1 bit 0 (start-sent), with status-1 at select 2. Control bit 2 is the acknowledge enable and control bit 1 requests a STOP; writing 0 to bits 0 or 1 has no effect.
- R2: A write to the data register (select 1) while start-sent is set clears start-sent and shifts that byte out MSB first. Its bit 0 is the read/write bit, and 1 means read.
- R3: An ACK on the address sets status-1 bit 1 (address-matched), and SCL stays low while it is set. It is cleared only by a read of status-1 followed directly by a read of status-2 (select 3). A status-2 read without that preceding status-1 read leaves it set.
- R4: A byte that moves into the data register sets status-1 bit 3 (receive-not-empty), and reading the data register clears it.
- R5: When a byte finishes while the data register is still unread, status-1 bit 2 (transfer-finished) is set and SCL is held low for as long as that lasts.
- R6: Reading the data register during that stall returns the old byte, moves the waiting byte in, clears transfer-finished, keeps receive-not-empty at 1 and restarts reception.
- R7: The acknowledge bit of each received byte is 0 if the acknowledge enable is 1 at the start of that bit, and 1 (NACK) otherwise.
- R8: A pending STOP request is issued after the current byte has reached the data register: SDA rises while SCL is high, and status-2 bit 0 (busy) then drops to 0.
- R9: A start request pending at a byte end produces a repeated START without any STOP in between and sets start-sent again.
- R10: A NACK on the address sets status-1 bit 4 (acknowledge-failure), leaves address-matched clear and ends with a STOP. A new start request clears the failure flag.
- R11: A data-register read in the very cycle a byte completes, with receive-not-empty at 1, returns the previous byte. The new byte then enters the data register, receive-not-empty stays 1 and no stall occurs.
- R12: SDA changes only while SCL is low, except for START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects) |
| bus_sel | input | 2 | Register select: 0 control, 1 data, 2 status-1, 3 status-2 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The sensitive overlap is a software read of the data register landing in the same clock as the end of a byte's acknowledge bit. At that moment the read tries to clear receive-not-empty while the finished byte tries to either fill the register or trigger a stall. The bench waits for the target model to see SCL rise on a byte's acknowledge bit, and then places a single-cycle read strobe exactly two quarter periods later, on the edge where SCL falls. It judges the result from the returned byte (the old one), from status-1 showing receive-not-empty without transfer-finished, and from the next read returning the new byte.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_ADDR,
        ST_ADDR,
        ST_ADDR_HOLD,
        ST_RX_BIT,
        ST_RX_ACK,
        ST_STRETCH,
        ST_STOP,
        ST_RESTART
    } ctl_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_STAT1 = 2'd2;
    localparam logic [1:0] SEL_STAT2 = 2'd3;

    localparam int CT_START = 0;
    localparam int CT_STOP  = 1;
    localparam int CT_ACK   = 2;

    localparam int FL_SB   = 0;
    localparam int FL_ADDR = 1;
    localparam int FL_BTF  = 2;
    localparam int FL_RXNE = 3;
    localparam int FL_AF   = 4;
    localparam int FL_W    = 5;

endpackage

// File: rtl/i2crx_clkdiv.sv
module i2crx_clkdiv #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2crx_core.sv
module i2crx_core
    import i2crx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic            run,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_sel,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic            scl_o,
    output logic            sda_o,
    input  logic            sda_i,
    output logic [FL_W-1:0] flags,
    output logic            busy
);
    ctl_state_e state, after_byte;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] tx_sh, rx_sh, dreg;
    logic       ack_en, start_req, stop_req, ackin, s1_seen;
    logic       sb, addr_f, btf, rxne, af;

    wire ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
    wire data_wr = bus_wr && (bus_sel == SEL_DATA);
    wire data_rd = bus_rd && (bus_sel == SEL_DATA);
    wire s1_rd   = bus_rd && (bus_sel == SEL_STAT1);
    wire s2_rd   = bus_rd && (bus_sel == SEL_STAT2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;  q <= '0;  bitn <= '0;
            tx_sh <= '0;  rx_sh <= '0;  dreg <= '0;
            scl_o <= 1'b1;  sda_o <= 1'b1;
            ack_en <= 1'b0;  start_req <= 1'b0;  stop_req <= 1'b0;
            ackin <= 1'b1;  s1_seen <= 1'b0;
            sb <= 1'b0;  addr_f <= 1'b0;  btf <= 1'b0;  rxne <= 1'b0;  af <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ack_en <= bus_wdata[CT_ACK];
                if (bus_wdata[CT_START]) begin
                    start_req <= 1'b1;
                    af        <= 1'b0;
                end
                if (bus_wdata[CT_STOP]) stop_req <= 1'b1;
            end
            if (bus_rd || bus_wr) s1_seen <= s1_rd && addr_f;
            if (s2_rd && s1_seen) addr_f <= 1'b0;
            if (data_rd && state != ST_STRETCH) rxne <= 1'b0;
            if (tick) q <= q + 2'd1;

            unique case (state)
                ST_IDLE: if (start_req) state <= ST_START;
                ST_START: if (tick) begin
                    if (q == 2'd0) sda_o <= 1'b0;
                    if (q == 2'd2) scl_o <= 1'b0;
                    if (q == 2'd3) begin
                        sb <= 1'b1;  start_req <= 1'b0;  state <= ST_WAIT_ADDR;
                    end
                end
                ST_WAIT_ADDR: if (data_wr) begin
                    tx_sh <= bus_wdata;  sb <= 1'b0;  bitn <= '0;  state <= ST_ADDR;
                end
                ST_ADDR: if (tick) begin
                    if (q == 2'd0) sda_o <= bitn[3] ? 1'b1 : tx_sh[7];
                    if (q == 2'd1) scl_o <= 1'b1;
                    if (q == 2'd2 && bitn[3]) ackin <= sda_i;
                    if (q == 2'd3) begin
                        scl_o <= 1'b0;
                        if (!bitn[3]) begin
                            tx_sh <= {tx_sh[6:0], 1'b0};
                            bitn  <= bitn + 4'd1;
                        end else if (!ackin) begin
                            addr_f <= 1'b1;  state <= ST_ADDR_HOLD;
                        end else begin
                            af <= 1'b1;  state <= ST_STOP;
                        end
                    end
                end
                ST_ADDR_HOLD: if (!addr_f) begin
                    bitn <= '0;  state <= ST_RX_BIT;
                end
                ST_RX_BIT: if (tick) begin
                    if (q == 2'd0) sda_o <= 1'b1;
                    if (q == 2'd1) scl_o <= 1'b1;
                    if (q == 2'd2) rx_sh <= {rx_sh[6:0], sda_i};
                    if (q == 2'd3) begin
                        scl_o <= 1'b0;
                        bitn  <= bitn + 4'd1;
                        if (bitn == 4'd7) state <= ST_RX_ACK;
                    end
                end
                ST_RX_ACK: if (tick) begin
                    if (q == 2'd0) sda_o <= !ack_en;
                    if (q == 2'd1) scl_o <= 1'b1;
                    if (q == 2'd3) begin
                        scl_o <= 1'b0;
                        if (rxne && !data_rd) begin
                            btf <= 1'b1;  state <= ST_STRETCH;
                        end else begin
                            dreg <= rx_sh;  rxne <= 1'b1;  bitn <= '0;  state <= after_byte;
                        end
                    end
                end
                ST_STRETCH: if (data_rd) begin
                    dreg <= rx_sh;  rxne <= 1'b1;  btf <= 1'b0;  bitn <= '0;
                    state <= after_byte;
                end
                ST_STOP: if (tick) begin
                    if (q == 2'd0) sda_o <= 1'b0;
                    if (q == 2'd1) scl_o <= 1'b1;
                    if (q == 2'd2) sda_o <= 1'b1;
                    if (q == 2'd3) begin
                        stop_req <= 1'b0;  state <= ST_IDLE;
                    end
                end
                ST_RESTART: if (tick) begin
                    if (q == 2'd0) sda_o <= 1'b1;
                    if (q == 2'd1) scl_o <= 1'b1;
                    if (q == 2'd3) state <= ST_START;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        after_byte = stop_req ? ST_STOP : (start_req ? ST_RESTART : ST_RX_BIT);
        run  = !(state inside {ST_IDLE, ST_WAIT_ADDR, ST_ADDR_HOLD, ST_STRETCH});
        busy = (state != ST_IDLE);
        flags = '0;
        flags[FL_SB]   = sb;
        flags[FL_ADDR] = addr_f;
        flags[FL_BTF]  = btf;
        flags[FL_RXNE] = rxne;
        flags[FL_AF]   = af;
        unique case (bus_sel)
            SEL_CTRL:  bus_rdata = {5'd0, ack_en, stop_req, start_req};
            SEL_DATA:  bus_rdata = dreg;
            SEL_STAT1: bus_rdata = {{(8-FL_W){1'b0}}, flags};
            SEL_STAT2: bus_rdata = {7'd0, busy};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master #(
    parameter int QDIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       scl_o,
    output logic       sda_o,
    input  logic       sda_i
);
    logic                        tick, run, busy;
    logic [i2crx_pkg::FL_W-1:0]  st_flags;

    i2crx_clkdiv #(.QDIV(QDIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    i2crx_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i),
        .flags(st_flags), .busy(busy)
    );
endmodule

// File: rtl/i2c_rd_master_chk.sv
module i2c_rd_master_chk
    import i2crx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            scl_o,
    input logic            bus_wr,
    input logic [1:0]      bus_sel,
    input logic [FL_W-1:0] flags
);
    a_r5_stall_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FL_BTF] |-> !scl_o);

    a_r5_stall_needs_full_dr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_BTF]) |-> flags[FL_RXNE]);

    a_r3_addr_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FL_ADDR] |-> !scl_o);

    a_r2_sb_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_SB] && bus_wr && bus_sel == SEL_DATA) |=> !flags[FL_SB]);

    a_r10_fail_without_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_AF]) |-> !flags[FL_ADDR]);
endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .flags(st_flags)
);

// File: tb/i2c_rd_master_test.sv
module i2c_rd_master_test;
    localparam int QDIV = 4;
    localparam logic [6:0] TGT = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic scl_o, sda_o, sda_i;
    logic slv_drv = 1'b1;

    always #4 clk = ~clk;
    assign sda_i = sda_o & slv_drv;

    i2c_rd_master #(.QDIV(QDIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural target model and bus reference
    logic pscl = 1'b1, psda = 1'b1;
    int ph = 0, acnt = 0, dcnt = 0, gen = 0;
    int starts = 0, stops = 0, proto_err = 0, ack_rise_no = -1;
    logic [7:0] abyte = 8'd0, txb = 8'd0;
    logic matched = 1'b0, last_ack = 1'b1;
    logic [7:0] sent_q[$];
    int ack_q[$];

    task automatic load_byte();
        txb = 8'(gen * 53 + 27);
        gen++;
        sent_q.push_back(txb);
        slv_drv = txb[7];
        dcnt = 1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (pscl && scl_o && psda != sda_i) begin
                // R12: SDA may move under a high SCL only outside a bit in flight
                if ((ph == 2 && dcnt >= 1 && dcnt <= 8) || (ph == 1 && acnt >= 1 && acnt <= 8))
                    proto_err++;
                if (!sda_i) begin starts++; ph = 1; acnt = 0; slv_drv = 1'b1; end
                else begin stops++; ph = 0; slv_drv = 1'b1; end
            end else if (!pscl && scl_o) begin
                if (ph == 1 && acnt < 8) begin abyte = {abyte[6:0], sda_i}; acnt++; end
                else if (ph == 2 && dcnt == 9) begin
                    last_ack = sda_i;
                    ack_q.push_back(int'(sda_i));
                    ack_rise_no = sent_q.size() - 1;
                end
            end else if (pscl && !scl_o) begin
                if (ph == 1) begin
                    if (acnt == 8) begin
                        matched = (abyte[7:1] == TGT);
                        slv_drv = !matched;
                        acnt = 9;
                    end else if (acnt == 9) begin
                        slv_drv = 1'b1;
                        if (matched && abyte[0]) begin ph = 2; load_byte(); end
                        else ph = 0;
                    end
                end else if (ph == 2) begin
                    if (dcnt < 8) begin slv_drv = txb[7 - dcnt]; dcnt++; end
                    else if (dcnt == 8) begin slv_drv = 1'b1; dcnt = 9; end
                    else if (!last_ack) load_byte();
                    else begin ph = 0; slv_drv = 1'b1; end
                end
            end
            pscl = scl_o;
            psda = sda_i;
        end
    end

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic poll(input logic [7:0] mask, input string req);
        logic [7:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd2, v);
            if ((v & mask) != 0) return;
        end
        chk(req, "flag never set", 0, int'(mask));
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run hung actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int k0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        rd(2'd2, v); chk("R1", "status-1 after reset", v, 8'h00);
        rd(2'd3, v); chk("R8", "busy after reset", v, 8'h00);
        chk("R12", "lines idle after reset", {scl_o, sda_o}, 2'b11);

        // ---- transfer 1: five bytes, STOP at the end
        wr(2'd0, 8'h05);
        poll(8'h01, "R1");
        chk("R1", "START seen", starts, 1);
        rd(2'd3, v); chk("R8", "busy during transfer", v, 8'h01);
        wr(2'd1, {TGT, 1'b1});
        rd(2'd2, v); chk("R2", "start-sent cleared by address write", v & 8'h01, 0);
        poll(8'h02, "R3");
        chk("R2", "address byte on bus", abyte, {TGT, 1'b1});
        rd(2'd1, v);
        rd(2'd3, v);
        rd(2'd2, v); chk("R3", "addr flag survives lone status-2 read", v & 8'h02, 8'h02);
        repeat (60) @(negedge clk);
        chk("R3", "SCL low while addr flag set", scl_o, 0);
        rd(2'd3, v);
        rd(2'd2, v); chk("R3", "addr flag cleared by status-1 then status-2", v & 8'h02, 0);

        repeat (500) @(negedge clk);
        rd(2'd2, v); chk("R5", "receive-not-empty and transfer-finished", v, 8'h0C);
        repeat (100) @(negedge clk);
        chk("R5", "SCL held low in stall", scl_o, 0);

        rd(2'd1, v); chk("R6", "byte 0", v, sent_q[0]);
        rd(2'd2, v); chk("R6", "after release: rxne kept, btf cleared", v & 8'h0C, 8'h08);
        poll(8'h04, "R5");
        rd(2'd1, v); chk("R6", "byte 1", v, sent_q[1]);
        poll(8'h04, "R5");
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R6", "byte 2", v, sent_q[2]);
        wr(2'd0, 8'h02);
        poll(8'h04, "R5");
        rd(2'd1, v); chk("R6", "byte 3", v, sent_q[3]);
        poll(8'h08, "R4");
        rd(2'd1, v); chk("R4", "byte 4", v, sent_q[4]);
        rd(2'd2, v); chk("R4", "rxne cleared by data read", v & 8'h08, 0);
        for (int i = 0; i < 4000; i++) begin
            rd(2'd3, v);
            if (v == 8'h00) break;
        end
        chk("R8", "busy dropped after STOP", v, 8'h00);
        chk("R8", "STOP seen", stops, 1);
        chk("R7", "ack count", ack_q.size(), 5);
        if (ack_q.size() == 5) begin
            chk("R7", "acks on bytes 0-3 sum", ack_q[0] + ack_q[1] + ack_q[2] + ack_q[3], 0);
            chk("R7", "NACK on final byte", ack_q[4], 1);
        end

        // ---- transfer 2: read at byte end, repeated START, address NACK
        k0 = sent_q.size();
        wr(2'd0, 8'h05);
        poll(8'h01, "R1");
        wr(2'd1, {TGT, 1'b1});
        poll(8'h02, "R3");
        rd(2'd3, v);
        poll(8'h08, "R4");
        wait (ack_rise_no == k0 + 1);
        repeat (2 * QDIV - 1) @(negedge clk);
        bus_sel = 2'd1; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R11", "read at byte end returns older byte", v, sent_q[k0]);
        rd(2'd2, v); chk("R11", "rxne set, no stall", v & 8'h0C, 8'h08);
        rd(2'd1, v); chk("R11", "new byte in data register", v, sent_q[k0 + 1]);
        wr(2'd0, 8'h01);
        poll(8'h01, "R9");
        chk("R9", "repeated START seen", starts, 3);
        chk("R9", "no STOP before repeated START", stops, 1);
        rd(2'd1, v); chk("R9", "final byte before restart", v, sent_q[k0 + 2]);
        wr(2'd1, {7'h15, 1'b1});
        poll(8'h10, "R10");
        rd(2'd2, v); chk("R10", "failure flag without addr flag", v, 8'h10);
        for (int i = 0; i < 4000; i++) begin
            rd(2'd3, v);
            if (v == 8'h00) break;
        end
        chk("R10", "STOP after address NACK", stops, 2);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R1", "zero write leaves requests clear", v & 8'h03, 0);
        chk("R12", "no SDA change inside a bit", proto_err, 0);
        chk("R12", "lines idle at end", {scl_o, sda_o}, 2'b11);

        done = 1;
        summary();
        $finish;
    end
endmodule